// File: doc/BRIEF.md
# Error injection countdown controller

This block is a software-armed pseudo-fault timer for a processor error-reporting node. Software loads a reload value into one register and writes a 32-bit control word into another. Arming the control word copies the reload value into a countdown counter, which then drops by one on every clock. When the counter reaches zero it expires. Each error class whose enable bit is set then raises a one-cycle injection strobe. The classes are corrected, deferred and uncontained. After expiry the counter either reloads and runs again or stops at zero, as the restart bit selects.

The error-recording logic downstream consumes the strobes as if real faults had occurred. Syndrome capture, recording and interrupt signalling lie outside this block. The current counter value and a running flag come out as plain outputs, so the timing can be observed. All outputs are registered. The reset is synchronous and active-high.

Top module: `err_inject_timer`

## Requirements
- R1: The control word at address 0 keeps its fields at fixed bit positions: bit 31 arms the countdown, bit 30 selects restart, bit 6 enables the corrected class, bit 5 enables the deferred class and bit 4 enables the uncontained class. Reading address 0 returns these bits as they were last written.
- R2: Bits 29 to 7 and 3 to 0 of the control word always read as zero, whatever value was written to them.
- R3: A synchronous reset clears all of the following to zero: the control word, the reload register, the counter, the running flag and all three strobes.
- R4: A write that changes bit 31 from 0 to 1 loads the reload value into the counter on that clock edge. From that edge on, `cnt_running` is 1.
- R5: While running, and when not at zero, the counter decreases by exactly one per clock.
- R6: With restart set, the clock edge at which a running counter is at zero reloads the counter from the reload register and keeps it running. With reload value N, expiries therefore come every N+1 clocks.
- R7: With restart clear, a running counter at zero stops: `cnt_running` falls, the counter holds at zero, and no further strobes occur until the countdown is armed again.
- R8: One clock after each expiry edge, `inj_ce`, `inj_de` and `inj_ue` are high for that single cycle exactly when their own enable bits (6, 5, 4) are set. They are low in every cycle that does not follow an expiry.
- R9: A write that clears bit 31 stops the countdown at once: the counter keeps its value, `cnt_running` falls, and no strobe follows. This holds even when the counter is at zero in that cycle.
- R10: A control write with bit 31 at 1 while bit 31 is already 1 does not reload the counter. Counting continues.
- R11: A reload value of zero makes the first counted edge after arming an expiry.
- R12: The reload register at address 1 holds 32 bits. Read data for any address appears on `rd_data` one clock after `rd_addr` is presented. Addresses 2 and 3 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 reload) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| inj_ce | output | 1 | Corrected-class injection strobe |
| inj_de | output | 1 | Deferred-class injection strobe |
| inj_ue | output | 1 | Uncontained-class injection strobe |
| cnt_value | output | 32 | Current counter value |
| cnt_running | output | 1 | Counter is actively counting |

## Verification
A wrong counter value shows on `cnt_value` in the cycle after the faulty update. A wrong running flag shows on `cnt_running` in that same cycle. A misplaced expiry or a missing reload also shifts the strobes: they arrive early, late or not at all, one cycle behind the expiry edge. A corrupted control field shows in the next readback and changes which strobes fire. A behavioural model compares every output in every cycle, so any such divergence is reported in the cycle it first reaches a port.

// File: rtl/eit_pkg.sv
package eit_pkg;
  localparam int DATA_W = 32;
  localparam int N_CLS  = 3;

  // control word bit positions
  localparam int BIT_ARM = 31;
  localparam int BIT_RST = 30;
  localparam int BIT_CE  = 6;
  localparam int BIT_DE  = 5;
  localparam int BIT_UE  = 4;

  localparam int OFS_CTRL   = 0;
  localparam int OFS_RELOAD = 1;

  localparam logic [DATA_W-1:0] CTRL_MASK =
    (DATA_W'(1) << BIT_ARM) | (DATA_W'(1) << BIT_RST) |
    (DATA_W'(1) << BIT_CE)  | (DATA_W'(1) << BIT_DE)  | (DATA_W'(1) << BIT_UE);

  typedef struct packed {
    logic arm;
    logic restart;
    logic ue;
    logic de;
    logic ce;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[BIT_ARM] = c.arm;
    w[BIT_RST] = c.restart;
    w[BIT_CE]  = c.ce;
    w[BIT_DE]  = c.de;
    w[BIT_UE]  = c.ue;
    return w;
  endfunction
endpackage

// File: rtl/eit_regs.sv
module eit_regs
  import eit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              arm_rise,
  output logic              arm_clear
);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);

  logic wr_ctrl, wr_rel;
  logic [DATA_W-1:0] rel_ext;

  assign wr_ctrl   = wr_en && (wr_addr == A_CTRL);
  assign wr_rel    = wr_en && (wr_addr == A_RELOAD);
  assign arm_rise  = wr_ctrl && wr_data[BIT_ARM] && !ctrl_q.arm;
  assign arm_clear = wr_ctrl && !wr_data[BIT_ARM];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.arm     <= wr_data[BIT_ARM];
      ctrl_q.restart <= wr_data[BIT_RST];
      ctrl_q.ce      <= wr_data[BIT_CE];
      ctrl_q.de      <= wr_data[BIT_DE];
      ctrl_q.ue      <= wr_data[BIT_UE];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reload_q <= '0;
    else if (wr_rel) reload_q <= wr_data[CNT_W-1:0];
  end

  always_comb begin
    rel_ext = '0;
    rel_ext[CNT_W-1:0] = reload_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        A_CTRL:   rd_data <= ctrl_pack(ctrl_q);
        A_RELOAD: rd_data <= rel_ext;
        default:  rd_data <= '0;
      endcase
    end
  end

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_addr) == A_CTRL) |-> ((rd_data & ~CTRL_MASK) == '0));
endmodule

// File: rtl/eit_core.sv
module eit_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             halt,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             expire
);
  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign expire  = run_q && at_zero && !halt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= reload;
      run_q <= 1'b1;
    end else if (halt) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (at_zero) begin
        if (restart) cnt_q <= reload;
        else         run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !at_zero && !load && !halt) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/eit_strobe.sv
module eit_strobe #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         expire,
  input  logic [N-1:0] cls_en,
  output logic [N-1:0] inj
);
  for (genvar i = 0; i < N; i++) begin : g_cls
    logic q;
    always_ff @(posedge clk) begin
      if (rst) q <= 1'b0;
      else     q <= expire & cls_en[i];
    end
    assign inj[i] = q;
  end
endmodule

// File: rtl/err_inject_timer.sv
module err_inject_timer
  import eit_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              inj_ce,
  output logic              inj_de,
  output logic              inj_ue,
  output logic [CNT_W-1:0]  cnt_value,
  output logic              cnt_running
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             arm_rise, arm_clear, expire;
  logic [N_CLS-1:0] cls_en, inj;

  eit_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_q(ctrl_q), .reload_q(reload_q),
    .arm_rise(arm_rise), .arm_clear(arm_clear)
  );

  eit_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .load(arm_rise), .halt(arm_clear),
    .restart(ctrl_q.restart), .reload(reload_q),
    .cnt_q(cnt_value), .run_q(cnt_running), .expire(expire)
  );

  assign cls_en = {ctrl_q.ue, ctrl_q.de, ctrl_q.ce};

  eit_strobe #(.N(N_CLS)) u_strobe (
    .clk(clk), .rst(rst), .expire(expire), .cls_en(cls_en), .inj(inj)
  );

  assign inj_ce = inj[0];
  assign inj_de = inj[1];
  assign inj_ue = inj[2];

  // R4
  arm_load_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q.arm) |-> ((cnt_value == $past(reload_q)) && cnt_running));

  // R9
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.arm |=> !(inj_ce || inj_de || inj_ue));

  // R8
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    (inj_ce || inj_de || inj_ue) |-> ($past(cnt_running) && ($past(cnt_value) == '0)));
endmodule

// File: tb/sim_err_inject_timer.sv
module sim_err_inject_timer;
  localparam int CNT_W  = 32;
  localparam int ADDR_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic inj_ce, inj_de, inj_ue;
  logic [CNT_W-1:0] cnt_value;
  logic cnt_running;

  always #2 clk = ~clk;

  err_inject_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .inj_ce(inj_ce), .inj_de(inj_de),
    .inj_ue(inj_ue), .cnt_value(cnt_value), .cnt_running(cnt_running)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_arm, m_rs, m_ce, m_de, m_ue;
  logic [31:0] m_rel, m_cnt, m_rd;
  bit m_run;
  bit [2:0] m_inj;

  always @(posedge clk) begin : model
    bit wc, wrl, rise, clr, exp_now;
    if (rst) begin
      {m_arm, m_rs, m_ce, m_de, m_ue, m_run} = '0;
      m_rel = 0; m_cnt = 0; m_rd = 0; m_inj = 0;
    end else begin
      wc   = wr_en && wr_addr == 0;
      wrl  = wr_en && wr_addr == 1;
      rise = wc && wr_data[31] && !m_arm;
      clr  = wc && !wr_data[31];
      exp_now = m_run && m_cnt == 0 && !clr;
      m_inj = exp_now ? {m_ue, m_de, m_ce} : 3'b000;
      case (rd_addr)
        0: m_rd = {m_arm, m_rs, 23'd0, m_ce, m_de, m_ue, 4'd0};
        1: m_rd = m_rel;
        default: m_rd = 0;
      endcase
      if (rise) begin
        m_cnt = m_rel; m_run = 1;
      end else if (clr) begin
        m_run = 0;
      end else if (m_run) begin
        if (m_cnt == 0) begin
          if (m_rs) m_cnt = m_rel; else m_run = 0;
        end else m_cnt = m_cnt - 1;
      end
      if (wc) begin
        m_arm = wr_data[31]; m_rs = wr_data[30];
        m_ce = wr_data[6]; m_de = wr_data[5]; m_ue = wr_data[4];
      end
      if (wrl) m_rel = wr_data;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 model cnt_value", cnt_value, m_cnt);
      chk("R6 model cnt_running", cnt_running, m_run);
      chk("R8 model strobes", {inj_ue, inj_de, inj_ce}, m_inj);
      chk("R12 model rd_data", rd_data, m_rd);
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  initial begin : main
    logic [31:0] v;
    logic [31:0] snap;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 cnt_value", cnt_value, 0);
    chk("R3 cnt_running", cnt_running, 0);
    chk("R3 strobes", {inj_ue, inj_de, inj_ce}, 0);
    rd(0, v); chk("R3 ctrl", v, 0);
    rd(1, v); chk("R3 reload", v, 0);

    wr(1, 32'hA5A5_F00D);
    rd(1, v); chk("R12 reload readback", v, 32'hA5A5_F00D);
    rd(2, v); chk("R12 unused addr", v, 0);
    wr(1, 32'd5);

    wr(0, 32'hFFFF_FFFF);
    chk("R4 loaded", cnt_value, 5);
    chk("R4 running", cnt_running, 1);
    repeat (2) @(negedge clk);
    chk("R5 decrement", cnt_value, 3);
    rd(0, v);
    chk("R1 R2 ctrl readback", v, 32'hC000_0070);
    @(negedge clk);
    chk("R5 at zero", cnt_value, 0);
    @(negedge clk);
    chk("R8 strobes at expiry", {inj_ue, inj_de, inj_ce}, 3'b111);
    chk("R6 reloaded", cnt_value, 5);
    chk("R6 still running", cnt_running, 1);
    @(negedge clk);
    chk("R8 single cycle", {inj_ue, inj_de, inj_ce}, 3'b000);

    v = cnt_value;
    wr(0, 32'hC000_0070);
    chk("R10 no reload", cnt_value, v - 2);

    v = cnt_value;
    wr(0, 32'h4000_0070);
    chk("R9 frozen value", cnt_value, v - 1);
    chk("R9 stopped", cnt_running, 0);
    snap = cnt_value;
    repeat (10) begin
      @(negedge clk);
      chk("R9 hold", cnt_value, snap);
      chk("R9 no strobe", {inj_ue, inj_de, inj_ce}, 0);
    end

    wr(1, 32'd3);
    wr(0, 32'h8000_0020);
    chk("R4 armed", cnt_value, 3);
    repeat (3) @(negedge clk);
    chk("R7 reaches zero", cnt_value, 0);
    @(negedge clk);
    chk("R8 deferred only", {inj_ue, inj_de, inj_ce}, 3'b010);
    chk("R7 stopped", cnt_running, 0);
    repeat (10) begin
      @(negedge clk);
      chk("R7 stays zero", cnt_value, 0);
      chk("R7 no strobe", {inj_ue, inj_de, inj_ce}, 0);
    end

    wr(0, 32'h0);
    wr(1, 32'd0);
    wr(0, 32'hC000_0010);
    chk("R11 armed at zero", cnt_running, 1);
    chk("R11 no early strobe", {inj_ue, inj_de, inj_ce}, 0);
    @(negedge clk);
    chk("R11 first counted edge expires", {inj_ue, inj_de, inj_ce}, 3'b100);
    @(negedge clk);
    chk("R11 R6 repeats", {inj_ue, inj_de, inj_ce}, 3'b100);
    wr(0, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd_addr = ADDR_W'($urandom_range(0, 3));
      case ($urandom_range(0, 7))
        0: begin
          wr_en = 1'b1; wr_addr = 0;
          wr_data = $urandom() | ($urandom_range(0, 3) != 0 ? 32'h8000_0000 : 32'h0);
        end
        1: begin
          wr_en = 1'b1; wr_addr = 1; wr_data = $urandom_range(0, 12);
        end
        default: wr_en = 1'b0;
      endcase
    end
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule